// File: doc/BRIEF.md
# Deferred Fault Commit Unit

This block holds the deferred-fault flags of a speculative pipeline. There is one flag per architectural register, kept in two banks: integer and floating point. Loads that may not trap mark their destination register with a flag instead of raising a fault. When logging is switched on, such a load also fills a small table of fault-status entries, each with a destination register, a bank bit and a faulting address. The record port is how these facts enter the block.

Two operations act on the flags. A commit turns a pending flag into a precise exception request, so that the fault is reported at a known point in the program. A clear discards the flags silently. Either operation can name one register or all registers of a bank. In all-registers mode, an upper or lower half of the bank takes part only when the caller reports that half as available.

When logging is active, the operation then walks the status table one entry per cycle. It zeroes every entry that matches, together with that entry's address. A done strobe closes the operation, and on a commit the exception request rides with it. A permission-denied strobe at the request turns the whole operation into a no-op.

Top module: `defer_commit_unit`

## Requirements
- R1: In single-register mode (op_all_i=0), the operation clears only flag op_reg_i of the bank chosen by op_float_i (1 = floating point). On a commit, the pending state is the value of that flag before the clear.
- R2: In all-registers mode, the upper half of the chosen bank (indices NREG/2 to NREG-1) is cleared only when hi_avail_i=1. The lower half (indices 0 to NREG/2-1) is cleared only when lo_avail_i=1. The other bank is never touched.
- R3: In all-registers mode, a commit is pending when an available half holds any set flag.
- R4: Flags are cleared on the cycle the operation is accepted, whether or not a fault was pending, and on both commit (op_commit_i=1) and clear (op_commit_i=0).
- R5: A commit asserts commit_exc_o together with done_o when, and only when, ctl_valid_i=1, log_en_i=1 and the commit was pending.
- R6: A status entry matches when it is valid, its bank bit equals op_float_i, and either its register equals op_reg_i or all-registers mode is selected. A matching entry is zeroed in all fields, including its address. Other entries keep their values.
- R7: When ctl_valid_i=1 and log_en_i=1, a clear purges matching entries and never asserts commit_exc_o. A commit purges only when it was pending.
- R8: A purge scans entries 0 to L-1, one per cycle, where L = min(ent_cnt_i, NENT). busy_o is high while the scan runs. done_o is sampled high L+1 cycles after the request cycle, counting the request cycle as cycle 0. With no purge, or with L=0, done_o is sampled high 1 cycle after the request.
- R9: A request with deny_i=1 has no effect and produces no done_o. A request made while busy_o is high is ignored.
- R10: A record (rec_valid_i) sets flag rec_reg_i in the bank chosen by rec_float_i. When ctl_valid_i=1 and log_en_i=1, it also writes {valid=1, bank bit, register, address} into the lowest invalid entry whose index is below ent_cnt_i. If there is no such entry, nothing is written. A record is ignored while busy_o or op_valid_i is high.
- R11: After reset, all flags and entries are zero and busy_o, done_o and commit_exc_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_valid_i | input | 1 | Control setting is valid |
| log_en_i | input | 1 | Status logging enabled |
| ent_cnt_i | input | CW | Number of status entries in use |
| op_valid_i | input | 1 | Operation request |
| op_commit_i | input | 1 | 1 = commit, 0 = clear |
| op_all_i | input | 1 | All-registers mode |
| op_reg_i | input | RW | Target register index |
| op_float_i | input | 1 | Bank select, 1 = floating point |
| hi_avail_i | input | 1 | Upper register half available |
| lo_avail_i | input | 1 | Lower register half available |
| deny_i | input | 1 | Access denied, operation aborted |
| rec_valid_i | input | 1 | Record a deferred fault |
| rec_float_i | input | 1 | Bank of the faulting register |
| rec_reg_i | input | RW | Faulting destination register |
| rec_addr_i | input | AW | Faulting address |
| busy_o | output | 1 | Status scan in progress |
| done_o | output | 1 | Operation complete, one cycle |
| commit_exc_o | output | 1 | Commit exception request, with done_o |
| gr_flags_o | output | NREG | Integer bank flags |
| fr_flags_o | output | NREG | Floating-point bank flags |
| ent_valid_o | output | NENT | Entry valid bits |
| ent_fr_o | output | NENT | Entry bank bits |
| ent_reg_o | output | NENT*RW | Entry registers, entry i at bits i*RW |
| ent_addr_o | output | NENT*AW | Entry addresses, entry i at bits i*AW |

## Verification
The assertions assume that records and requests arrive only in an idle cycle, and that the control inputs (ctl_valid_i, log_en_i, ent_cnt_i) stay stable while an operation runs. The bench changes the control inputs only between operations. It drives at most one request or record per idle cycle. The one exception is a deliberate stray request and record during a scan, which are expected to be ignored. Random entry counts from 0 to 6 go past NENT, so both the clamped scan length and a full log are exercised.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_SCAN = 1'b1} seq_state_e;
endpackage

// File: rtl/dfc_flag_bank.sv
module dfc_flag_bank #(
  parameter int NREG = 64,
  parameter int RW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [RW-1:0]   set_idx_i,
  input  logic            clr_i,
  input  logic            all_i,
  input  logic [RW-1:0]   idx_i,
  input  logic            hi_avail_i,
  input  logic            lo_avail_i,
  output logic [NREG-1:0] flags_o,
  output logic            pending_o
);
  localparam int HALF = NREG / 2;

  logic [NREG-1:0] flags_q;
  logic [NREG-1:0] clr_mask;
  logic            hi_any, lo_any;

  assign hi_any = |flags_q[NREG-1:HALF];
  assign lo_any = |flags_q[HALF-1:0];

  always_comb begin
    clr_mask = '0;
    if (all_i) begin
      if (hi_avail_i) clr_mask[NREG-1:HALF] = '1;
      if (lo_avail_i) clr_mask[HALF-1:0]    = '1;
    end else begin
      clr_mask[idx_i] = 1'b1;
    end
  end

  assign pending_o = all_i ? ((hi_avail_i && hi_any) || (lo_avail_i && lo_any))
                           : flags_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_q <= '0;
    else if (clr_i)  flags_q <= flags_q & ~clr_mask;
    else if (set_i)  flags_q[set_idx_i] <= 1'b1;
  end

  assign flags_o = flags_q;

  // R1
  single_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !all_i |=> !flags_q[$past(idx_i)]);
  // R2
  hi_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && all_i && hi_avail_i |=> flags_q[NREG-1:HALF] == '0);
  // R2
  hi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && all_i && !hi_avail_i |=> $stable(flags_q[NREG-1:HALF]));
  // R2
  lo_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && all_i && !lo_avail_i |=> $stable(flags_q[HALF-1:0]));
endmodule

// File: rtl/dfc_status_log.sv
module dfc_status_log #(
  parameter int NENT = 4,
  parameter int RW   = 6,
  parameter int AW   = 32,
  parameter int CW   = $clog2(NENT + 1),
  parameter int IW   = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               wr_fr_i,
  input  logic [RW-1:0]      wr_reg_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [CW-1:0]      wr_lim_i,
  input  logic               scan_i,
  input  logic [IW-1:0]      scan_idx_i,
  input  logic               scan_fr_i,
  input  logic               scan_all_i,
  input  logic [RW-1:0]      scan_reg_i,
  output logic [NENT-1:0]    ent_valid_o,
  output logic [NENT-1:0]    ent_fr_o,
  output logic [NENT*RW-1:0] ent_reg_o,
  output logic [NENT*AW-1:0] ent_addr_o
);
  logic [NENT-1:0] vld_q, fr_q;
  logic [RW-1:0]   reg_q  [NENT];
  logic [AW-1:0]   addr_q [NENT];
  logic [NENT-1:0] wr_hit, purge_hit;

  // lowest free slot below the configured count
  always_comb begin
    logic found;
    found  = 1'b0;
    wr_hit = '0;
    for (int i = 0; i < NENT; i++) begin
      if (!found && !vld_q[i] && (CW'(i) < wr_lim_i)) begin
        found     = 1'b1;
        wr_hit[i] = wr_i;
      end
    end
  end

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    logic match;
    assign match = vld_q[g] && (fr_q[g] == scan_fr_i) &&
                   (scan_all_i || (reg_q[g] == scan_reg_i));
    assign purge_hit[g] = scan_i && (scan_idx_i == IW'(g)) && match;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        fr_q[g]   <= 1'b0;
        reg_q[g]  <= '0;
        addr_q[g] <= '0;
      end else if (purge_hit[g]) begin
        vld_q[g]  <= 1'b0;
        fr_q[g]   <= 1'b0;
        reg_q[g]  <= '0;
        addr_q[g] <= '0;
      end else if (wr_hit[g]) begin
        vld_q[g]  <= 1'b1;
        fr_q[g]   <= wr_fr_i;
        reg_q[g]  <= wr_reg_i;
        addr_q[g] <= wr_addr_i;
      end
    end

    assign ent_reg_o[g*RW +: RW]  = reg_q[g];
    assign ent_addr_o[g*AW +: AW] = addr_q[g];

    // R6
    purge_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      purge_hit[g] |=> !vld_q[g] && (addr_q[g] == '0) && (reg_q[g] == '0));
  end

  assign ent_valid_o = vld_q;
  assign ent_fr_o    = fr_q;

  // R10
  one_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hit));
  // R10
  wr_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (wr_hit != '0) |=> $countones(vld_q) == $countones($past(vld_q)) + 1);
endmodule

// File: rtl/dfc_seq.sv
module dfc_seq
  import dfc_pkg::*;
#(
  parameter int NENT = 4,
  parameter int CW   = $clog2(NENT + 1),
  parameter int IW   = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic          deny_i,
  input  logic          commit_i,
  input  logic          pending_i,
  input  logic          log_on_i,
  input  logic [CW-1:0] cnt_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic [IW-1:0] scan_idx_o,
  output logic          done_o,
  output logic          exc_o
);
  seq_state_e    state_q;
  logic [IW-1:0] idx_q, last_q;
  logic          exc_pend_q, done_q, exc_q;
  logic [CW-1:0] lim;
  logic          purge, raise;

  assign lim      = (cnt_i > CW'(NENT)) ? CW'(NENT) : cnt_i;
  assign accept_o = (state_q == SEQ_IDLE) && op_valid_i && !deny_i;
  assign purge    = log_on_i && (!commit_i || pending_i);
  assign raise    = commit_i && log_on_i && pending_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      idx_q      <= '0;
      last_q     <= '0;
      exc_pend_q <= 1'b0;
      done_q     <= 1'b0;
      exc_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      exc_q  <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: if (accept_o) begin
          exc_pend_q <= raise;
          if (purge && (lim != '0)) begin
            state_q <= SEQ_SCAN;
            idx_q   <= '0;
            last_q  <= IW'(lim - CW'(1));
          end else begin
            done_q <= 1'b1;
            exc_q  <= raise;
          end
        end
        SEQ_SCAN: begin
          if (idx_q == last_q) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
            exc_q   <= exc_pend_q;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q == SEQ_SCAN);
  assign scan_idx_o = idx_q;
  assign done_o     = done_q;
  assign exc_o      = exc_q;

  // R5
  exc_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> done_o);
  // R8
  scan_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> idx_q <= last_q);
  // R8
  no_done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
  // R9
  deny_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE) && op_valid_i && deny_i |=> !done_o && !busy_o);
endmodule

// File: rtl/defer_commit_unit.sv
module defer_commit_unit #(
  parameter int NREG = 64,
  parameter int NENT = 4,
  parameter int AW   = 32,
  parameter int RW   = $clog2(NREG),
  parameter int CW   = $clog2(NENT + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctl_valid_i,
  input  logic               log_en_i,
  input  logic [CW-1:0]      ent_cnt_i,
  input  logic               op_valid_i,
  input  logic               op_commit_i,
  input  logic               op_all_i,
  input  logic [RW-1:0]      op_reg_i,
  input  logic               op_float_i,
  input  logic               hi_avail_i,
  input  logic               lo_avail_i,
  input  logic               deny_i,
  input  logic               rec_valid_i,
  input  logic               rec_float_i,
  input  logic [RW-1:0]      rec_reg_i,
  input  logic [AW-1:0]      rec_addr_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               commit_exc_o,
  output logic [NREG-1:0]    gr_flags_o,
  output logic [NREG-1:0]    fr_flags_o,
  output logic [NENT-1:0]    ent_valid_o,
  output logic [NENT-1:0]    ent_fr_o,
  output logic [NENT*RW-1:0] ent_reg_o,
  output logic [NENT*AW-1:0] ent_addr_o
);
  localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;
  localparam int NBANK = 2;

  logic          log_on, accept, rec_ok, pending;
  logic [IW-1:0] scan_idx;
  logic          tgt_fr_q, tgt_all_q;
  logic [RW-1:0] tgt_reg_q;
  logic [NREG-1:0] bank_flags [NBANK];
  logic [NBANK-1:0] bank_pend;

  assign log_on = ctl_valid_i && log_en_i;
  assign rec_ok = rec_valid_i && !busy_o && !op_valid_i;

  // bank 0: integer, bank 1: floating point
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dfc_flag_bank #(.NREG(NREG), .RW(RW)) i_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (rec_ok && (rec_float_i == b[0])),
      .set_idx_i  (rec_reg_i),
      .clr_i      (accept && (op_float_i == b[0])),
      .all_i      (op_all_i),
      .idx_i      (op_reg_i),
      .hi_avail_i (hi_avail_i),
      .lo_avail_i (lo_avail_i),
      .flags_o    (bank_flags[b]),
      .pending_o  (bank_pend[b])
    );
  end

  assign gr_flags_o = bank_flags[0];
  assign fr_flags_o = bank_flags[1];
  assign pending    = op_float_i ? bank_pend[1] : bank_pend[0];

  dfc_seq #(.NENT(NENT), .CW(CW), .IW(IW)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .deny_i     (deny_i),
    .commit_i   (op_commit_i),
    .pending_i  (pending),
    .log_on_i   (log_on),
    .cnt_i      (ent_cnt_i),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .scan_idx_o (scan_idx),
    .done_o     (done_o),
    .exc_o      (commit_exc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_fr_q  <= 1'b0;
      tgt_all_q <= 1'b0;
      tgt_reg_q <= '0;
    end else if (accept) begin
      tgt_fr_q  <= op_float_i;
      tgt_all_q <= op_all_i;
      tgt_reg_q <= op_reg_i;
    end
  end

  dfc_status_log #(.NENT(NENT), .RW(RW), .AW(AW), .CW(CW), .IW(IW)) i_log (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (rec_ok && log_on),
    .wr_fr_i     (rec_float_i),
    .wr_reg_i    (rec_reg_i),
    .wr_addr_i   (rec_addr_i),
    .wr_lim_i    (ent_cnt_i),
    .scan_i      (busy_o),
    .scan_idx_i  (scan_idx),
    .scan_fr_i   (tgt_fr_q),
    .scan_all_i  (tgt_all_q),
    .scan_reg_i  (tgt_reg_q),
    .ent_valid_o (ent_valid_o),
    .ent_fr_o    (ent_fr_o),
    .ent_reg_o   (ent_reg_o),
    .ent_addr_o  (ent_addr_o)
  );

  // R4
  flags_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !op_all_i && !op_float_i |=> !gr_flags_o[$past(op_reg_i)]);
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(gr_flags_o) && $stable(fr_flags_o));
endmodule

// File: tb/test_defer_commit_unit.sv
module test_defer_commit_unit;
  localparam int NREG = 64;
  localparam int NENT = 4;
  localparam int AW   = 32;
  localparam int RW   = $clog2(NREG);
  localparam int CW   = $clog2(NENT + 1);
  localparam int HALF = NREG / 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_valid = 0, log_en = 0, op_valid = 0, op_commit = 0, op_all = 0;
  logic op_float = 0, hi_avail = 0, lo_avail = 0, deny = 0;
  logic rec_valid = 0, rec_float = 0;
  logic [CW-1:0] ent_cnt = '0;
  logic [RW-1:0] op_reg = '0, rec_reg = '0;
  logic [AW-1:0] rec_addr = '0;
  logic busy, done, exc;
  logic [NREG-1:0] gr_flags, fr_flags;
  logic [NENT-1:0] ent_valid, ent_fr;
  logic [NENT*RW-1:0] ent_reg;
  logic [NENT*AW-1:0] ent_addr;

  defer_commit_unit #(.NREG(NREG), .NENT(NENT), .AW(AW)) i_defer_commit_unit (
    .clk_i(clk), .rst_ni(rst_n), .ctl_valid_i(ctl_valid), .log_en_i(log_en),
    .ent_cnt_i(ent_cnt), .op_valid_i(op_valid), .op_commit_i(op_commit),
    .op_all_i(op_all), .op_reg_i(op_reg), .op_float_i(op_float),
    .hi_avail_i(hi_avail), .lo_avail_i(lo_avail), .deny_i(deny),
    .rec_valid_i(rec_valid), .rec_float_i(rec_float), .rec_reg_i(rec_reg),
    .rec_addr_i(rec_addr), .busy_o(busy), .done_o(done), .commit_exc_o(exc),
    .gr_flags_o(gr_flags), .fr_flags_o(fr_flags), .ent_valid_o(ent_valid),
    .ent_fr_o(ent_fr), .ent_reg_o(ent_reg), .ent_addr_o(ent_addr));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [NREG-1:0] m_g = '0, m_f = '0;
  logic [NENT-1:0] m_v = '0, m_fr = '0;
  logic [RW-1:0]   m_r [NENT];
  logic [AW-1:0]   m_a [NENT];

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NENT*RW-1:0] exp_reg();
    logic [NENT*RW-1:0] v;
    for (int i = 0; i < NENT; i++) v[i*RW +: RW] = m_r[i];
    return v;
  endfunction

  function automatic logic [NENT*AW-1:0] exp_addr();
    logic [NENT*AW-1:0] v;
    for (int i = 0; i < NENT; i++) v[i*AW +: AW] = m_a[i];
    return v;
  endfunction

  function automatic int lim_of(input int c);
    return (c > NENT) ? NENT : c;
  endfunction

  task automatic check_state(input string req);
    chk(gr_flags === m_g, req, gr_flags, m_g);
    chk(fr_flags === m_f, req, fr_flags, m_f);
    chk(ent_valid === m_v && ent_fr === m_fr, req, {ent_valid, ent_fr}, {m_v, m_fr});
    chk(ent_reg === exp_reg(), req, ent_reg, exp_reg());
    chk(ent_addr === exp_addr(), req, ent_addr, exp_addr());
  endtask

  // R10 record model
  task automatic do_rec(input logic fr, input logic [RW-1:0] r, input logic [AW-1:0] a);
    @(negedge clk);
    rec_valid = 1; rec_float = fr; rec_reg = r; rec_addr = a;
    if (fr) m_f[r] = 1'b1; else m_g[r] = 1'b1;
    if (ctl_valid && log_en) begin
      for (int i = 0; i < NENT; i++) begin
        if (!m_v[i] && i < int'(ent_cnt)) begin
          m_v[i] = 1; m_fr[i] = fr; m_r[i] = r; m_a[i] = a;
          break;
        end
      end
    end
    @(negedge clk);
    rec_valid = 0;
    check_state("R10");
  endtask

  task automatic do_op(input logic cm, input logic all, input logic [RW-1:0] r,
                       input logic fr, input logic hi, input logic lo, input bit stray);
    logic [NREG-1:0] f;
    logic pend, logon, e_exc, purge;
    int lim, e_lat, n;
    f = fr ? m_f : m_g;
    pend = all ? ((hi && (f[NREG-1:HALF] != '0)) || (lo && (f[HALF-1:0] != '0))) : f[r];
    if (all) begin
      if (hi) f[NREG-1:HALF] = '0;
      if (lo) f[HALF-1:0] = '0;
    end else f[r] = 1'b0;
    if (fr) m_f = f; else m_g = f;
    logon = ctl_valid && log_en;
    e_exc = cm && logon && pend;
    purge = logon && (!cm || pend);
    lim   = lim_of(int'(ent_cnt));
    e_lat = (purge && lim > 0) ? lim + 1 : 1;
    if (purge)
      for (int i = 0; i < lim; i++)
        if (m_v[i] && m_fr[i] == fr && (all || m_r[i] == r)) begin
          m_v[i] = 0; m_fr[i] = 0; m_r[i] = '0; m_a[i] = '0;
        end
    @(negedge clk);
    op_valid = 1; op_commit = cm; op_all = all; op_reg = r; op_float = fr;
    hi_avail = hi; lo_avail = lo;
    @(negedge clk);
    op_valid = 0;
    n = 1;
    if (stray && !done) begin
      // R9: request and record during scan are ignored
      chk(busy === 1'b1, "R8", busy, 1);
      op_valid = 1; op_commit = 0; op_all = 1; op_float = ~fr;
      hi_avail = 1; lo_avail = 1;
      rec_valid = 1; rec_float = fr; rec_reg = r; rec_addr = 32'hdead;
      @(negedge clk);
      op_valid = 0; rec_valid = 0;
      n++;
    end
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == e_lat, "R8", n, e_lat);
    chk(exc === e_exc, cm ? "R5" : "R7", exc, e_exc);
    check_state(all ? "R2" : "R1");
  endtask

  task automatic set_ctl(input logic v, input logic l, input int c);
    @(negedge clk);
    ctl_valid = v; log_en = l; ent_cnt = CW'(c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) begin m_r[i] = '0; m_a[i] = '0; end
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy === 0 && done === 0 && exc === 0, "R11", {busy, done, exc}, 0);
    check_state("R11");
    rst_n = 1;

    // directed: single commit with logging, purge and exception
    set_ctl(1, 1, 4);
    do_rec(0, 6'd5, 32'h100);
    do_rec(1, 6'd5, 32'h104);
    do_rec(0, 6'd40, 32'h108);
    do_op(1, 0, 6'd5, 0, 0, 0, 0);      // R6: float entry for reg 5 kept
    do_op(1, 0, 6'd5, 0, 0, 0, 0);      // R4: nothing pending now, no exception
    // R3/R2: all mode, upper half only
    do_rec(0, 6'd3, 32'h10c);
    do_op(1, 1, 6'd0, 0, 1, 0, 0);      // R3: reg 40 pending in upper half
    do_op(1, 1, 6'd0, 0, 0, 0, 0);      // R3: no half available, not pending
    // R7: clear purges without exception
    do_op(0, 1, 6'd0, 1, 1, 1, 0);
    // R9: deny has no effect
    do_rec(1, 6'd9, 32'h200);
    @(negedge clk);
    op_valid = 1; op_commit = 1; op_all = 1; op_float = 1; hi_avail = 1; lo_avail = 1;
    deny = 1;
    @(negedge clk);
    chk(done === 0 && busy === 0, "R9", {done, busy}, 0);
    op_valid = 0; deny = 0;
    @(negedge clk);
    chk(done === 0, "R9", done, 0);
    check_state("R9");
    // R9: stray request during a scan
    do_rec(0, 6'd12, 32'h300);
    do_op(1, 0, 6'd12, 0, 0, 0, 1);
    // R8: count of zero, log full with count 2
    set_ctl(1, 1, 0);
    do_rec(0, 6'd20, 32'h400);
    do_op(1, 0, 6'd20, 0, 0, 0, 0);
    set_ctl(1, 1, 2);
    do_rec(0, 6'd21, 32'h500);
    do_rec(0, 6'd22, 32'h504);
    do_rec(0, 6'd23, 32'h508);
    // R5: control invalid means no exception, no purge
    set_ctl(0, 1, 4);
    do_op(1, 0, 6'd21, 0, 0, 0, 0);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 8) == 0)
        set_ctl(($urandom % 6) != 0, ($urandom % 4) != 0, $urandom % 7);
      if (($urandom % 10) < 6)
        do_rec($urandom % 2, RW'($urandom), $urandom);
      else
        do_op($urandom % 2, ($urandom % 3) == 0, RW'($urandom % 8), $urandom % 2,
              $urandom % 2, $urandom % 2, ($urandom % 4) == 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule